// File: doc/BRIEF.md
# Byte Bit-Clear Read-Modify-Write Sequencer

This block carries out a single test-and-clear operation on one bit of a byte held in memory. A decoder hands it a start pulse together with the already-decoded operand fields. The sequencer reads the addressed byte through a byte-wide request/grant memory port. It then writes the same byte back with the chosen bit forced to zero. Finally it reports through a zero flag whether that bit had been clear before the write.

Two operand forms are accepted, chosen by `form_reg`:
- **Displacement form:** the byte address is a base register value plus a sign-extended 16-bit displacement, and a 3-bit bit index comes straight from the instruction.
- **Register form:** the byte address is the base register value itself, and the bit index is taken from the low bits of a second register value.

The read and the write of one operation are issued back to back, with no other access in between. A pipeline can therefore treat the sequence as indivisible. Nothing other than the zero flag is produced as a result.

Top module: `bitclr_rmw`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done`, `z_flag` and `mem_req` are all 0.
- R2: With `form_reg` = 0, the byte address is `base_val` plus `disp_val` sign-extended to 32 bits, modulo 2^32, and the bit index is `bit_imm`.
- R3: With `form_reg` = 1, the byte address is `base_val` and the bit index is `bit_val[2:0]`; bits 31:3 of `bit_val`, `bit_imm` and `disp_val` have no effect.
- R4: Each operation issues exactly two memory requests: first a read (`mem_we` = 0), then a write (`mem_we` = 1) to the same address, with no other request in between.
- R5: The written byte equals the byte read, with the selected bit (index 0 = least significant) forced to 0 and all other bits unchanged.
- R6: On completion, `z_flag` is 1 if the selected bit was 0 in the byte read and 0 if it was 1. `z_flag` changes only in a cycle where `done` is 1, and holds its value at all other times.
- R7: `done` is high for exactly one cycle, in the cycle after the write is granted. The start-to-done delay is 4 + G_rd + G_wr + L cycles, measured from the cycle in which `start` is sampled, where G_rd and G_wr are the cycles each request waits for its grant and L is the number of cycles between the read grant cycle and `mem_rvalid`, less one.
- R8: While a request is not granted, `mem_req` stays high and `mem_we`, `mem_addr` and `mem_wdata` stay unchanged.
- R9: A `start` pulse that arrives while an operation is in progress is ignored: it causes no memory access, no `done` and no change to any byte.
- R10: Operand inputs are sampled only in the cycle `start` is accepted; changing them afterwards does not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| form_reg | input | 1 | 0 = displacement form, 1 = register form |
| base_val | input | 32 | Base register value (address operand) |
| disp_val | input | 16 | Signed displacement for the displacement form |
| bit_imm | input | 3 | Bit index for the displacement form |
| bit_val | input | 32 | Register holding the bit index for the register form |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Byte to write |
| mem_gnt | input | 1 | Request accepted at this rising edge |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8 | Read data byte |
| z_flag | output | 1 | Zero flag: selected bit was clear before the write |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume a well-behaved memory:
- `mem_gnt` is raised only against an outstanding request.
- Each granted read is answered by exactly one `mem_rvalid` pulse, in a later cycle, carrying its byte.
- No `mem_rvalid` arrives outside a pending read.

The bench's memory responder keeps to these rules. It grants after a programmable number of wait cycles, and it returns read data once, a programmable number of cycles after the grant. `start` pulses given during an operation are the only stimulus outside the idle window, and R9 requires those to be dropped.

// File: rtl/bitclr_pkg.sv
package bitclr_pkg;

   // sequencer phases of one test-and-clear operation
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RD   = 3'd1,
      ST_WAIT = 3'd2,
      ST_WR   = 3'd3,
      ST_DONE = 3'd4
   } bc_state_e;

endpackage

// File: rtl/bitclr_addr.sv
// Effective byte address: base plus sign-extended displacement, or base alone.
module bitclr_addr #(
   parameter int ADDR_W = 32,
   parameter int DISP_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              use_disp,
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] addr_q
);

   localparam int EXT_W = ADDR_W - DISP_W;

   logic [ADDR_W-1:0] disp_ext;
   logic [ADDR_W-1:0] addr_d;

   generate
      if (EXT_W > 0) begin : g_sext
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_same
         assign disp_ext = disp[ADDR_W-1:0];
      end
   endgenerate

   always_comb begin
      addr_d = base;
      if (use_disp) begin
         addr_d = base + disp_ext;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= addr_d;
      end
   end

endmodule

// File: rtl/bitclr_mask.sv
// Bit-index selection and one-hot mask register.
module bitclr_mask #(
   parameter int DATA_W = 8,
   parameter int REG_W  = 32,
   parameter int SEL_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              use_imm,
   input  logic [SEL_W-1:0]  bit_imm,
   input  logic [REG_W-1:0]  bit_val,
   output logic [DATA_W-1:0] mask_q
);

   logic [SEL_W-1:0]  sel;
   logic [DATA_W-1:0] dec;

   assign sel = use_imm ? bit_imm : bit_val[SEL_W-1:0];

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_dec
         assign dec[i] = (sel == SEL_W'(i));
      end
      if (REG_W > SEL_W) begin : g_hi
         // upper register bits do not take part in the selection
         logic unused_hi;
         assign unused_hi = ^bit_val[REG_W-1:SEL_W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (load) begin
         mask_q <= dec;
      end
   end

endmodule

// File: rtl/bitclr_fsm.sv
// Phase sequencer: idle, read request, wait for data, write request, done.
module bitclr_fsm
   import bitclr_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      mem_gnt,
   input  logic      mem_rvalid,
   output logic      load,
   output bc_state_e state_q
);

   bc_state_e state_d;

   assign load = (state_q == ST_IDLE) && start;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start)      state_d = ST_RD;
         ST_RD:   if (mem_gnt)    state_d = ST_WAIT;
         ST_WAIT: if (mem_rvalid) state_d = ST_WR;
         ST_WR:   if (mem_gnt)    state_d = ST_DONE;
         ST_DONE:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

endmodule

// File: rtl/bitclr_rmw.sv
// Byte bit-clear read-modify-write sequencer (top).
module bitclr_rmw #(
   parameter  int ADDR_W = 32,
   parameter  int DISP_W = 16,
   parameter  int REG_W  = 32,
   parameter  int DATA_W = 8,
   localparam int SEL_W  = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              form_reg,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [DISP_W-1:0] disp_val,
   input  logic [SEL_W-1:0]  bit_imm,
   input  logic [REG_W-1:0]  bit_val,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              z_flag,
   output logic              done
);

   import bitclr_pkg::*;

   // elaboration-time parameter checks
   generate
      if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("bitclr_rmw: DATA_W must be a power of two >= 2");
      end
      if (ADDR_W < DISP_W) begin : g_bad_disp
         $error("bitclr_rmw: ADDR_W must not be narrower than DISP_W");
      end
      if (REG_W < SEL_W) begin : g_bad_reg
         $error("bitclr_rmw: REG_W too narrow for a bit index");
      end
   endgenerate

   bc_state_e         state_q;
   logic              load;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] byte_q;
   logic              z_q;

   bitclr_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .load       (load),
      .state_q    (state_q)
   );

   bitclr_addr #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .use_disp (!form_reg),
      .base     (base_val),
      .disp     (disp_val),
      .addr_q   (mem_addr)
   );

   bitclr_mask #(
      .DATA_W (DATA_W),
      .REG_W  (REG_W),
      .SEL_W  (SEL_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .use_imm (!form_reg),
      .bit_imm (bit_imm),
      .bit_val (bit_val),
      .mask_q  (mask_q)
   );

   // captured byte from memory
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (state_q == ST_WAIT && mem_rvalid) begin
         byte_q <= mem_rdata;
      end
   end

   // zero flag: set when the selected bit was already clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         z_q <= 1'b0;
      end else if (state_q == ST_WR && mem_gnt) begin
         z_q <= ~|(byte_q & mask_q);
      end
   end

   assign mem_req   = (state_q == ST_RD) || (state_q == ST_WR);
   assign mem_we    = (state_q == ST_WR);
   assign mem_wdata = byte_q & ~mask_q;
   assign z_flag    = z_q;
   assign done      = (state_q == ST_DONE);

endmodule

// File: rtl/bitclr_rmw_chk.sv
// Property checker for bitclr_rmw, attached by bind.
module bitclr_rmw_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic              mem_rvalid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [DATA_W-1:0] mem_rdata,
   input logic              z_flag,
   input logic              done
);

   logic              rd_open;
   logic [ADDR_W-1:0] rd_addr_q;
   logic [DATA_W-1:0] rd_data_q;
   logic [DATA_W-1:0] wr_data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_open   <= 1'b0;
         rd_addr_q <= '0;
         rd_data_q <= '0;
         wr_data_q <= '0;
      end else begin
         if (mem_req && mem_gnt && !mem_we) begin
            rd_open   <= 1'b1;
            rd_addr_q <= mem_addr;
         end
         if (mem_req && mem_gnt && mem_we) begin
            rd_open   <= 1'b0;
            wr_data_q <= mem_wdata;
         end
         if (mem_rvalid && rd_open) begin
            rd_data_q <= mem_rdata;
         end
      end
   end

   // R1: nothing requested or signalled in the first cycle out of reset
   a_r1_quiet_after_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!mem_req && !done && !z_flag));

   // R4: once a read is granted, the next request is its write
   a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && rd_open) |-> mem_we);

   // R4: a write is only issued after a granted read
   a_r4_no_lone_write: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> rd_open);

   // R4: the write goes to the address that was read
   a_r4_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr == rd_addr_q));

   // R5: write data only clears, and at most one bit
   a_r5_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && rd_open) |->
         (((mem_wdata & ~rd_data_q) == '0) && ($countones(mem_wdata ^ rd_data_q) <= 1)));

   // R6: zero flag is set exactly when the write left the byte unchanged
   a_r6_z_value: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (z_flag == (wr_data_q == rd_data_q)));

   // R6: zero flag moves only together with done
   a_r6_z_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(z_flag));

   // R7: done is a single-cycle pulse
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: an ungranted request is held unchanged
   a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=>
         (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

endmodule

bind bitclr_rmw bitclr_rmw_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_we     (mem_we),
   .mem_gnt    (mem_gnt),
   .mem_rvalid (mem_rvalid),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .mem_rdata  (mem_rdata),
   .z_flag     (z_flag),
   .done       (done)
);

// File: tb/bitclr_rmw_bench.sv
module bitclr_rmw_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        form_reg = 1'b0;
   logic [31:0] base_val = '0;
   logic [15:0] disp_val = '0;
   logic [2:0]  bit_imm = '0;
   logic [31:0] bit_val = '0;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_gnt = 1'b0;
   logic        mem_rvalid = 1'b0;
   logic [7:0]  mem_rdata = '0;
   logic        z_flag;
   logic        done;

   always #(CLK_PERIOD / 2) clk = ~clk;

   bitclr_rmw u_bitclr_rmw (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .form_reg   (form_reg),
      .base_val   (base_val),
      .disp_val   (disp_val),
      .bit_imm    (bit_imm),
      .bit_val    (bit_val),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_gnt    (mem_gnt),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .z_flag     (z_flag),
      .done       (done)
   );

   typedef struct {
      logic        z;
      logic [31:0] a;
      logic [7:0]  nb;
      int          lat;
      string       tag;
   } exp_t;

   exp_t        exp_q[$];
   exp_t        mon_e;
   logic [7:0]  mem    [0:255];
   logic [7:0]  shadow [0:255];
   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc = 0;
   int          start_cyc = 0;
   int          gnt_delay = 0;
   int          gnt_wait = 0;
   int          rd_delay = 0;
   int          rd_cnt = 0;
   int          op_rd = 0;
   int          op_wr = 0;
   logic [31:0] op_rd_a = '0;
   logic [31:0] op_wr_a = '0;
   logic [7:0]  rd_a = '0;
   logic        z_prev = 1'b0;

   task automatic check(input bit ok, input string what,
                        input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", what, act, expv);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // cycle count and watchdog
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc > WATCHDOG) begin
         check(1'b0, "R7 watchdog expired (cycles)", 32'(cyc), 32'(WATCHDOG));
         summary();
         $finish;
      end
   end

   // memory responder: grant after gnt_delay waits, read data rd_delay+1 cycles later
   always @(negedge clk) begin
      mem_rvalid = 1'b0;
      if (rd_cnt > 0) begin
         rd_cnt = rd_cnt - 1;
         if (rd_cnt == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata  = mem[rd_a];
         end
      end
      mem_gnt = 1'b0;
      if (rst_n && mem_req) begin
         if (gnt_wait > 0) begin
            gnt_wait = gnt_wait - 1;
         end else begin
            mem_gnt  = 1'b1;
            gnt_wait = gnt_delay;
            if (mem_we) begin
               mem[mem_addr[7:0]] = mem_wdata;
               op_wr   = op_wr + 1;
               op_wr_a = mem_addr;
            end else begin
               rd_a    = mem_addr[7:0];
               rd_cnt  = rd_delay + 1;
               op_rd   = op_rd + 1;
               op_rd_a = mem_addr;
            end
         end
      end
   end

   // monitor: pops the scoreboard on every done pulse
   always @(negedge clk) begin
      if (rst_n) begin
         if (done) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9 done without a pending operation", 32'(done), 32'd0);
            end else begin
               mon_e = exp_q.pop_front();
               check(z_flag == mon_e.z, "R6 zero flag", 32'(z_flag), 32'(mon_e.z));
               check(mem[mon_e.a[7:0]] == mon_e.nb, "R5 byte after write",
                     32'(mem[mon_e.a[7:0]]), 32'(mon_e.nb));
               check(op_rd == 1 && op_wr == 1, "R4 accesses (reads*16+writes)",
                     32'(op_rd * 16 + op_wr), 32'd17);
               check(op_rd_a == mon_e.a, mon_e.tag, op_rd_a, mon_e.a);
               check(op_wr_a == mon_e.a, "R4 write address", op_wr_a, mon_e.a);
               check(cyc - start_cyc == mon_e.lat, "R7 start-to-done cycles",
                     32'(cyc - start_cyc), 32'(mon_e.lat));
            end
            op_rd = 0;
            op_wr = 0;
         end else if (z_flag !== z_prev) begin
            check(1'b0, "R6 zero flag changed without done", 32'(z_flag), 32'(z_prev));
         end
         z_prev = z_flag;
      end
   end

   // driver: computes the expected result from the requirements and starts one operation
   task automatic run_op(input bit frm, input logic [31:0] b, input logic [15:0] d,
                         input logic [2:0] ib, input logic [31:0] bv,
                         input int gd, input int rl);
      exp_t        e;
      logic [31:0] a;
      logic [2:0]  s;
      logic [7:0]  old;
      wait (exp_q.size() == 0);
      @(negedge clk);
      a      = frm ? b : b + {{16{d[15]}}, d};
      s      = frm ? bv[2:0] : ib;
      old    = shadow[a[7:0]];
      e.z    = ~old[s];
      e.a    = a;
      e.nb   = old & ~(8'h01 << s);
      e.lat  = 4 + 2 * gd + rl;
      e.tag  = frm ? "R3 register-form address" : "R2 displacement-form address";
      shadow[a[7:0]] = e.nb;
      gnt_delay = gd;
      gnt_wait  = gd;
      rd_delay  = rl;
      exp_q.push_back(e);
      start     = 1'b1;
      form_reg  = frm;
      base_val  = b;
      disp_val  = d;
      bit_imm   = ib;
      bit_val   = bv;
      start_cyc = cyc;
      @(negedge clk);
      start    = 1'b0;
      // R10: scramble operands while the operation runs
      form_reg = 1'($urandom);
      base_val = $urandom;
      disp_val = 16'($urandom);
      bit_imm  = 3'($urandom);
      bit_val  = $urandom;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem[i]    = 8'(i * 53 + 11);
         shadow[i] = mem[i];
      end
      mem[8'h45] = 8'hFF; shadow[8'h45] = 8'hFF;
      mem[8'h77] = 8'hFF; shadow[8'h77] = 8'hFF;

      // R1: reset state
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", 32'(done), 32'd0);
      check(z_flag == 1'b0, "R1 z_flag in reset", 32'(z_flag), 32'd0);
      check(mem_req == 1'b0, "R1 mem_req in reset", 32'(mem_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && mem_req == 1'b0 && z_flag == 1'b0,
            "R1 outputs after reset", {29'd0, done, mem_req, z_flag}, 32'd0);

      // R2/R6: bit 7 set then cleared, then the same bit again (already clear)
      run_op(1'b0, 32'h0000_0040, 16'h0005, 3'd7, 32'h0, 0, 0);
      run_op(1'b0, 32'h0000_0040, 16'h0005, 3'd7, 32'h0, 0, 0);
      // R2: address wraps past the top of the space
      run_op(1'b0, 32'hFFFF_FFF0, 16'h0020, 3'd0, 32'h0, 1, 0);
      // R2: negative displacement
      run_op(1'b0, 32'h0000_0100, 16'hFFF0, 3'd3, 32'h0, 0, 2);
      // R3: upper bits of the bit register and the immediate fields ignored
      run_op(1'b1, 32'h0000_0033, 16'h7FFF, 3'd5, 32'hFFFF_FFFA, 2, 3);
      run_op(1'b1, 32'h0000_0045, 16'h1234, 3'd7, 32'h8000_0000, 0, 1);
      run_op(1'b1, 32'h0000_0045, 16'h0000, 3'd0, 32'h0000_0008, 3, 0);

      // R9: a start pulse during a running operation is ignored
      run_op(1'b0, 32'h0000_0020, 16'h0000, 3'd1, 32'h0, 6, 2);
      @(negedge clk);
      start    = 1'b1;
      form_reg = 1'b1;
      base_val = 32'h0000_0077;
      bit_val  = 32'h0;
      @(negedge clk);
      start = 1'b0;
      wait (exp_q.size() == 0);
      repeat (8) @(negedge clk);
      check(mem[8'h77] == 8'hFF, "R9 byte at ignored-start address",
            32'(mem[8'h77]), 32'hFF);

      // mixed forms, bits and memory latencies
      for (int k = 0; k < 200; k++) begin
         run_op(1'($urandom), $urandom, 16'($urandom), 3'($urandom), $urandom,
                int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      end
      wait (exp_q.size() == 0);
      repeat (5) @(negedge clk);
      summary();
      $finish;
   end

endmodule